// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a burst memory access. An external start address is captured whenever either of two active-low address strobes is sampled low. Each later cycle in which the advance input is low and both strobes are high moves the burst forward by one beat. Only the two low address bits follow a four-beat pattern; the upper bits keep the value they were loaded with.

A static order-select input picks the pattern. When it is high, the low bits are the loaded start value XORed with the beat number (interleaved order). When it is low, they are the start value plus the beat number, modulo four (linear order). The start value is kept in its own register, so both patterns are computed directly from it and from the beat counter. A cycle with advance high and no strobe holds the address, which inserts a wait state. The counter feeds the row and column decode of a memory array and also reports the beat number. The array and the data path are not part of this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low at a clock edge, the block clears its state. After reset, `addr_out` is 0 and `beat_idx` is 0.
- R2: An edge that samples `strobe_cpu_n` low loads `addr_in` into `addr_out` and sets `beat_idx` to 0. `adv_n` is ignored on that edge.
- R3: An edge that samples `strobe_ctl_n` low, with `strobe_cpu_n` high, also loads `addr_in` and sets `beat_idx` to 0. `adv_n` is ignored on that edge too.
- R4: An edge that samples `adv_n` low with both strobes high increments `beat_idx` by 1, modulo 4.
- R5: An edge that samples `adv_n` high with both strobes high leaves `addr_out` and `beat_idx` unchanged.
- R6: With `order_sel` = 1, `addr_out[1:0]` equals the loaded start bits XOR `beat_idx`. For example, start 10 gives 10, 11, 00, 01.
- R7: With `order_sel` = 0, `addr_out[1:0]` equals the loaded start bits plus `beat_idx`, modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R8: `addr_out[18:2]` changes only on a load. After four advances, the low bits return to the start value and nothing carries into bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst order: 1 = interleaved (expected default), 0 = linear |
| addr_in | input | 19 | Start address captured on a strobe |
| addr_out | output | 19 | Current burst address |
| beat_idx | output | 2 | Beat number within the burst, 0 to 3 |

## Verification
The hardest case to reach from the ports is a burst that covers all four beats with wait states mixed in. The burst must run from a start value other than zero, carry all-ones upper bits, and cross the wrap without any strobe cutting it short. With fully random strobes this rarely happens, because a stray load restarts the burst. Directed sequences therefore load all-ones upper bits with each start value in both orders and step through the wrap with hold cycles in between. A long random run with rare strobes and an occasional change of order then covers loads that collide with advance.

// File: rtl/burst_pkg.sv
// Shared command type and decode for the burst address sequencer.
// Assumes the strobes and advance are synchronous and active low.
package burst_pkg;

    typedef enum logic [1:0] {
        BC_HOLD = 2'd0,
        BC_STEP = 2'd1,
        BC_LOAD = 2'd2
    } burst_cmd_e;

    // Any strobe wins over advance; advance counts only with both strobes idle.
    function automatic burst_cmd_e burst_decode(input logic cpu_n,
                                                input logic ctl_n,
                                                input logic adv_n);
        if (!cpu_n || !ctl_n) begin
            return BC_LOAD;
        end else if (!adv_n) begin
            return BC_STEP;
        end
        return BC_HOLD;
    endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
// Beat counter: clears on a load, wraps modulo 2**BEAT_W on a step, holds
// otherwise. Assumes cmd is decoded from inputs sampled at the same edge.
module burst_beat_ctr
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  burst_cmd_e        cmd,
    output logic [BEAT_W-1:0] beat
);

    // Beat register update per decoded command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else begin
            case (cmd)
                BC_LOAD: beat <= '0;
                BC_STEP: beat <= beat + 1'b1;
                default: beat <= beat;
            endcase
        end
    end

    p_load_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == BC_LOAD) |=> (beat == '0));

    p_step_counts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == BC_STEP) |=> (beat == BEAT_W'($past(beat) + 1'b1)));

    p_hold_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == BC_HOLD) |=> $stable(beat));

endmodule

// File: rtl/burst_addr_hold.sv
// Start-address register: captures the fixed upper bits and the original
// low start bits on a load. Assumes load is a one-cycle qualified strobe.
module burst_addr_hold #(
    parameter int HIGH_W = 17,
    parameter int LOW_W  = 2,
    localparam int ADDR_W = HIGH_W + LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [HIGH_W-1:0] upper,
    output logic [LOW_W-1:0]  start
);

    // Capture the start address; it is never modified by stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper <= '0;
            start <= '0;
        end else if (load) begin
            upper <= addr_in[ADDR_W-1:LOW_W];
            start <= addr_in[LOW_W-1:0];
        end
    end

    p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(upper) && $stable(start)));

endmodule

// File: rtl/burst_order_map.sv
// Maps the start bits and beat number to the current low address bits.
// Interleaved order XORs the beat in, linear order adds it modulo 2**LOW_W.
// Assumes order_sel is static during a burst.
module burst_order_map #(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] start,
    input  logic [LOW_W-1:0] beat,
    input  logic             order_sel,
    output logic [LOW_W-1:0] low
);

    logic [LOW_W-1:0] lin_low;
    logic [LOW_W-1:0] ilv_low;

    // Compute both orders and select one by the static mode input.
    always_comb begin
        lin_low = start + beat;
        ilv_low = start ^ beat;
        low     = order_sel ? ilv_low : lin_low;
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Top of the burst address sequencer. Loads a start address on either
// strobe and steps the low bits in interleaved or linear order on advance.
// Assumes all control inputs are synchronous to clk; order_sel is static.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [LOW_W-1:0]  beat_idx
);

    localparam int HIGH_W = ADDR_W - LOW_W;

    burst_cmd_e        cmd;
    logic [HIGH_W-1:0] upper_q;
    logic [LOW_W-1:0]  start_q;
    logic [LOW_W-1:0]  low_addr;

    // Decode the sampled strobes and advance into one command.
    always_comb begin
        cmd = burst_decode(strobe_cpu_n, strobe_ctl_n, adv_n);
    end

    burst_addr_hold #(
        .HIGH_W (HIGH_W),
        .LOW_W  (LOW_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cmd == BC_LOAD),
        .addr_in (addr_in),
        .upper   (upper_q),
        .start   (start_q)
    );

    burst_beat_ctr #(
        .BEAT_W (LOW_W)
    ) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .beat  (beat_idx)
    );

    burst_order_map #(
        .LOW_W (LOW_W)
    ) u_map (
        .start     (start_q),
        .beat      (beat_idx),
        .order_sel (order_sel),
        .low       (low_addr)
    );

    // Assemble the output address from fixed upper bits and mapped low bits.
    always_comb begin
        addr_out = {upper_q, low_addr};
    end

    p_wrap_to_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == BC_STEP && beat_idx == '1) |=>
            (addr_out[LOW_W-1:0] == start_q && $stable(addr_out[ADDR_W-1:LOW_W])));

    p_load_takes_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ctl_n || !strobe_cpu_n) |=>
            (addr_out[ADDR_W-1:LOW_W] == $past(addr_in[ADDR_W-1:LOW_W])));

endmodule

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;

    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          strobe_cpu_n, strobe_ctl_n, adv_n, order_sel;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_idx;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [AW-3:0] m_up;
    logic [1:0]    m_start;
    logic [1:0]    m_beat;

    always #4 clk = ~clk;

    burst_addr_gen u_burst_addr_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .adv_n        (adv_n),
        .order_sel    (order_sel),
        .addr_in      (addr_in),
        .addr_out     (addr_out),
        .beat_idx     (beat_idx)
    );

    function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] b,
                                           input logic ilv);
        return ilv ? (s ^ b) : 2'(s + b);
    endfunction

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update model at posedge, check at next negedge.
    task automatic cyc(input logic cpu, input logic ctl, input logic adv,
                       input logic ord, input logic [AW-1:0] a);
        string tag;
        strobe_cpu_n = cpu; strobe_ctl_n = ctl; adv_n = adv;
        order_sel = ord; addr_in = a;
        @(posedge clk);
        if (!cpu) begin
            tag = "R2"; m_up = a[AW-1:2]; m_start = a[1:0]; m_beat = 2'd0;
        end else if (!ctl) begin
            tag = "R3"; m_up = a[AW-1:2]; m_start = a[1:0]; m_beat = 2'd0;
        end else if (!adv) begin
            tag = "R4"; m_beat = m_beat + 2'd1;
        end else begin
            tag = "R5";
        end
        @(negedge clk);
        chk({tag, ord ? " R6" : " R7", " addr"}, addr_out,
            {m_up, exp_low(m_start, m_beat, ord)});
        chk({tag, " beat"}, {17'd0, beat_idx}, {17'd0, m_beat});
        chk("R8 upper", {2'd0, addr_out[AW-1:2]}, {2'd0, m_up});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        void'($urandom(32'd20417));
        rst_n = 1'b0; strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1;
        adv_n = 1'b0; order_sel = 1'b1; addr_in = '1;
        m_up = '0; m_start = '0; m_beat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 addr", addr_out, '0);
        chk("R1 beat", {17'd0, beat_idx}, '0);

        // R6 and R8: interleaved bursts from every start, all-ones upper bits, with waits.
        for (int s = 0; s < 4; s++) begin
            a = {17'h1FFFF, 2'(s)};
            cyc(1'b0, 1'b1, 1'b0, 1'b1, a);       // R2: adv low ignored on load
            for (int k = 0; k < 4; k++) begin
                cyc(1'b1, 1'b1, 1'b0, 1'b1, '0);
                if (k == 1) cyc(1'b1, 1'b1, 1'b1, 1'b1, '0);  // R5 wait state
            end
            chk("R8 wrap", addr_out, a);
        end

        // R7 and R8: linear bursts started from the controller strobe.
        for (int s = 0; s < 4; s++) begin
            a = {17'h1FFFF, 2'(s)};
            cyc(1'b1, 1'b0, 1'b0, 1'b0, a);       // R3: adv low ignored on load
            for (int k = 0; k < 4; k++) cyc(1'b1, 1'b1, 1'b0, 1'b0, '0);
            chk("R8 wrap", addr_out, a);
        end

        // R2/R3: both strobes together, then strobes in the middle of a burst.
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 19'h2A5A5);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, '0);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 19'h00003);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, '0);

        // Random mix: rare strobes, frequent advance, occasional order change.
        begin
            logic ord = 1'b1;
            for (int i = 0; i < 3000; i++) begin
                if ($urandom_range(0, 39) == 0) ord = ~ord;
                cyc($urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0,
                    $urandom_range(0, 3) == 0, ord, AW'($urandom));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule